// File: doc/BRIEF.md
# Triggered Capture Logic Analyzer

This block is a small on-chip capture core that sits beside a design under observation and runs on that design's clock. That clock comes from outside the chip and may be swept in frequency during a measurement. A controller on a separate clock of fixed frequency sets a condition word and raises an enable line. The core then watches a trigger bus. On the first cycle in which the trigger bus equals the condition word, it takes one snapshot of a data bus and raises a done indication.

The controller sees done, reads the snapshot at leisure, and raises clear. Clear puts the core back into its waiting state for the next measurement. Enable and clear enter the observed clock domain through two-flop synchronizers, and the controller holds each of them until it sees the effect. Done is a level that leaves the observed domain through a two-flop synchronizer into the controller clock. The snapshot does not change between done and clear, so the controller may read it without synchronizing each bit.

The trigger width and the data width are parameters, each from 1 to 128 bits. The defaults are 16 and 32. The condition word is quasi-static: the controller changes it only while enable is low.

Top module: `lac_top`

## Requirements
- R1: After reset, `done` is 0 and `cap_data` is all zeros.
- R2: While the synchronized enable is high and the core is waiting, a clock_ext edge with `trig` equal to `cond` stores `data` into `cap_data`. The stored value is the `data` value present at that edge.
- R3: While `enable` is low, a matching `trig` stores nothing: `cap_data` stays zero and `done` stays 0.
- R4: After a capture, `done` rises in the clk_ctl domain within a few clk_ctl cycles. It then stays high as a level until clear is applied.
- R5: Only the first match after enable is captured. Later matches and any later change on `data` leave `cap_data` unchanged until clear.
- R6: Clear returns the core to waiting. `done` falls, `cap_data` returns to zero, and a later match is captured again.
- R7: In a clock_ext cycle where the synchronized clear and a match are both present, clear wins and nothing is stored. A trigger held at a match for as long as clear is held causes no capture.
- R8: Capture, done and clear behave the same when clk_ext runs much slower than clk_ctl and when it runs faster than clk_ctl.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ext | input | 1 | Clock of the observed design; may vary in frequency |
| clk_ctl | input | 1 | Fixed-frequency controller clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| enable | input | 1 | Arms the trigger comparison (controller domain, held level) |
| clear | input | 1 | Returns the core to waiting (controller domain, held level) |
| cond | input | TRIG_W | Condition word compared with the trigger bus |
| trig | input | TRIG_W | Trigger bus from the observed design |
| data | input | DATA_W | Data bus from the observed design |
| done | output | 1 | Capture complete, synchronized to clk_ctl |
| cap_data | output | DATA_W | Captured snapshot, stable from done until clear |

## Verification
Two functions can fall in the same clock_ext cycle: the synchronized clear and a trigger match. The bench provokes this by holding the trigger bus at the condition word, with enable high, for the whole time clear is held. Every such cycle must store nothing and keep done low. When clear is released with the match still present, the bench expects the capture to take place, which shows that only the clear was blocking it.

// File: rtl/lac_pkg.sv
// Package: shared types and constants for the triggered capture analyzer.
// Assumes: imported by every module of the block.
package lac_pkg;
    // Number of flops in each clock-domain crossing synchronizer.
    localparam int SYNC_STAGES = 2;

    // Capture state: waiting for a match, or holding a snapshot.
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } cap_state_t;
endpackage

// File: rtl/lac_sync.sv
// Module: multi-bit level synchronizer built from a chain of flops.
// Assumes: each bit is an independent, slowly changing level that is held
// for longer than STAGES destination clock cycles.
module lac_sync #(
    parameter int W      = 1,
    parameter int STAGES = lac_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // First flop samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    // Remaining flops shift the level along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lac_match.sv
// Module: equality comparator between the trigger bus and the condition word.
// Assumes: both inputs are stable around the sampling edge of the observed clock.
module lac_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] trig,
    input  logic [W-1:0] cond,
    output logic         hit
);
    logic [W-1:0] bit_eq;

    // Per-bit agreement, reduced to one match flag.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign bit_eq[b] = ~(trig[b] ^ cond[b]);
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/lac_core.sv
// Module: capture state machine and snapshot register in the observed clock domain.
// Assumes: en_s and clr_s are already synchronized to clk. Clear has priority
// over capture. Only the first match after arming is stored.
module lac_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              clr_s,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    output logic              done_q,
    output logic [DATA_W-1:0] cap_q
);
    import lac_pkg::*;

    cap_state_t state;

    // State and snapshot update: clear first, then the first armed match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cap_q <= '0;
        end else if (clr_s) begin
            state <= ST_WAIT;
            cap_q <= '0;
        end else if (state == ST_WAIT && en_s && hit) begin
            state <= ST_HELD;
            cap_q <= data;
        end
    end

    assign done_q = (state == ST_HELD);

    // R2: an armed match while waiting stores the data present at that edge.
    p_capture_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && !clr_s && !done_q && hit) |=> (done_q && cap_q == $past(data)));

    // R3: without enable the core cannot leave the waiting state.
    p_no_capture_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !done_q) |=> !done_q);

    // R4: done is a level that only clear can drop.
    p_done_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_s) |=> done_q);

    // R5: the snapshot is frozen while held.
    p_snapshot_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_s) |=> $stable(cap_q));

    // R6, R7: clear empties the snapshot and wins over a same-cycle match.
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (!done_q && cap_q == '0));
endmodule

// File: rtl/lac_top.sv
// Module: top of the triggered capture analyzer. It brings enable and clear
// into the observed clock domain, compares trigger against condition, and
// returns done to the controller clock.
// Assumes: the controller holds enable and clear as levels until it sees
// their effect, and changes cond only while enable is low.
module lac_top #(
    parameter int TRIG_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk_ext,
    input  logic              clk_ctl,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clear,
    input  logic [TRIG_W-1:0] cond,
    input  logic [TRIG_W-1:0] trig,
    input  logic [DATA_W-1:0] data,
    output logic              done,
    output logic [DATA_W-1:0] cap_data
);
    logic [1:0] ctl_s;
    logic       hit;
    logic       done_ext;

    // Controller levels into the observed domain.
    lac_sync #(.W(2)) u_sync_in (
        .clk   (clk_ext),
        .rst_n (rst_n),
        .d     ({clear, enable}),
        .q     (ctl_s)
    );

    // Trigger comparison.
    lac_match #(.W(TRIG_W)) u_match (
        .trig (trig),
        .cond (cond),
        .hit  (hit)
    );

    // Capture state and snapshot.
    lac_core #(.DATA_W(DATA_W)) u_core (
        .clk    (clk_ext),
        .rst_n  (rst_n),
        .en_s   (ctl_s[0]),
        .clr_s  (ctl_s[1]),
        .hit    (hit),
        .data   (data),
        .done_q (done_ext),
        .cap_q  (cap_data)
    );

    // Done level back into the controller domain.
    lac_sync #(.W(1)) u_sync_out (
        .clk   (clk_ctl),
        .rst_n (rst_n),
        .d     (done_ext),
        .q     (done)
    );

    // R4: once seen by the controller, done stays up while clear is low.
    p_done_ctl_level_r4: assert property (@(posedge clk_ctl) disable iff (!rst_n)
        (done && !clear && !$past(clear)) |=> done);
endmodule

// File: tb/sim_lac_top.sv
`timescale 1ps/1ps
module sim_lac_top;
    localparam int TW = 16;
    localparam int DW = 32;

    // One vector: enable level, condition, trigger value, data value.
    typedef struct packed {
        logic          en;
        logic [TW-1:0] cond;
        logic [TW-1:0] trig;
        logic [DW-1:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'hA5C3, 16'hA5C3, 32'h1234_5678},
        '{1'b1, 16'hFFFF, 16'hFFFE, 32'hDEAD_BEEF},
        '{1'b0, 16'h0F0F, 16'h0F0F, 32'hCAFE_0001},
        '{1'b1, 16'h0000, 16'h0000, 32'hFFFF_FFFF},
        '{1'b1, 16'h8001, 16'h8001, 32'h0000_0001},
        '{1'b1, 16'h1234, 16'h4321, 32'h5555_AAAA}
    };

    logic          clk_ext = 1'b0;
    logic          clk_ctl = 1'b0;
    logic          rst_n   = 1'b0;
    logic          enable  = 1'b0;
    logic          clear   = 1'b0;
    logic [TW-1:0] cond    = '0;
    logic [TW-1:0] trig    = 16'hFFFF;
    logic [DW-1:0] data    = '0;
    logic          done;
    logic [DW-1:0] cap_data;

    int ext_half = 2000;
    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(ext_half) clk_ext = ~clk_ext;
    always #5000 clk_ctl = ~clk_ctl;

    lac_top #(.TRIG_W(TW), .DATA_W(DW)) u0 (
        .clk_ext  (clk_ext),
        .clk_ctl  (clk_ctl),
        .rst_n    (rst_n),
        .enable   (enable),
        .clear    (clear),
        .cond     (cond),
        .trig     (trig),
        .data     (data),
        .done     (done),
        .cap_data (cap_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ext_cycles(input int n);
        repeat (n) @(negedge clk_ext);
    endtask

    task automatic ctl_cycles(input int n);
        repeat (n) @(negedge clk_ctl);
    endtask

    // Hold clear until both domains have seen it, then release it.
    task automatic do_clear();
        clear = 1'b1;
        ext_cycles(6);
        ctl_cycles(4);
        clear = 1'b0;
        ext_cycles(6);
    endtask

    // Present one trigger/data value for a single clk_ext cycle.
    task automatic pulse(input logic [TW-1:0] t, input logic [DW-1:0] d);
        @(negedge clk_ext);
        trig = t;
        data = d;
        @(negedge clk_ext);
        trig = ~cond;
        data = ~d;
    endtask

    initial begin
        ext_cycles(5);
        ctl_cycles(5);
        rst_n = 1'b1;
        ext_cycles(2);
        ctl_cycles(2);
        // R1: reset state.
        check(done == 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
        check(cap_data == '0, "R1 cap_data after reset", cap_data, 32'd0);

        // R2, R3: vector table.
        for (int i = 0; i < NV; i++) begin
            logic          hit_exp;
            logic [DW-1:0] cap_exp;
            hit_exp = VECS[i].en && (VECS[i].trig == VECS[i].cond);
            cap_exp = hit_exp ? VECS[i].data : '0;
            do_clear();
            cond   = VECS[i].cond;
            trig   = ~VECS[i].cond;
            enable = VECS[i].en;
            ext_cycles(5);
            pulse(VECS[i].trig, VECS[i].data);
            check(cap_data == cap_exp, VECS[i].en ? "R2 vector cap_data" : "R3 vector cap_data",
                  cap_data, cap_exp);
            ctl_cycles(4);
            check(done == hit_exp, VECS[i].en ? "R4 vector done" : "R3 vector done",
                  {31'd0, done}, {31'd0, hit_exp});
            enable = 1'b0;
        end

        // R5: only the first match is kept.
        do_clear();
        cond = 16'h00AA;
        trig = 16'hFF55;
        enable = 1'b1;
        ext_cycles(5);
        pulse(16'h00AA, 32'h1111_1111);
        pulse(16'h00AA, 32'h2222_2222);
        data = 32'h9999_9999;
        ext_cycles(4);
        check(cap_data == 32'h1111_1111, "R5 first match kept", cap_data, 32'h1111_1111);
        ctl_cycles(4);
        check(done == 1'b1, "R5 done after first match", {31'd0, done}, 32'd1);

        // R4: done stays up over a long wait.
        ctl_cycles(200);
        check(done == 1'b1, "R4 done held as level", {31'd0, done}, 32'd1);
        check(cap_data == 32'h1111_1111, "R5 snapshot stable over wait", cap_data, 32'h1111_1111);

        // R6: clear empties the core.
        do_clear();
        ctl_cycles(3);
        check(done == 1'b0, "R6 done after clear", {31'd0, done}, 32'd0);
        check(cap_data == '0, "R6 cap_data after clear", cap_data, 32'd0);

        // R7: clear held with a continuous match stores nothing.
        clear = 1'b1;
        ext_cycles(6);
        trig = 16'h00AA;
        data = 32'h3333_3333;
        ext_cycles(10);
        ctl_cycles(4);
        check(cap_data == '0, "R7 clear beats match cap_data", cap_data, 32'd0);
        check(done == 1'b0, "R7 clear beats match done", {31'd0, done}, 32'd0);
        clear = 1'b0;
        ext_cycles(8);
        ctl_cycles(4);
        check(cap_data == 32'h3333_3333, "R6 recapture after clear", cap_data, 32'h3333_3333);
        check(done == 1'b1, "R6 done after recapture", {31'd0, done}, 32'd1);
        trig = 16'hFF55;

        // R8: slow observed clock.
        ext_half = 18500;
        ext_cycles(3);
        do_clear();
        check(done == 1'b0, "R8 slow clock clear", {31'd0, done}, 32'd0);
        pulse(16'h00AA, 32'h4444_4444);
        check(cap_data == 32'h4444_4444, "R8 slow clock capture", cap_data, 32'h4444_4444);
        ctl_cycles(4);
        check(done == 1'b1, "R8 slow clock done", {31'd0, done}, 32'd1);

        // R8: fast observed clock.
        ext_half = 1500;
        ext_cycles(3);
        do_clear();
        ctl_cycles(3);
        check(done == 1'b0, "R8 fast clock clear", {31'd0, done}, 32'd0);
        pulse(16'h00AA, 32'h6666_7777);
        check(cap_data == 32'h6666_7777, "R8 fast clock capture", cap_data, 32'h6666_7777);
        ctl_cycles(4);
        check(done == 1'b1, "R8 fast clock done", {31'd0, done}, 32'd1);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R8 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule